// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the bit clock and frame (word-select) clock of a serial audio link. In master mode it divides the master clock by a ratio picked by a 3-bit mode code, giving a bit clock at 64 times the sample rate and a frame clock at the sample rate. In slave mode it takes both clocks from outside, brings them into the master-clock domain and passes them through. It also reports whether the external link carries 32 or 48 bit clocks per frame.

The mode code also gives a slave/master flag and a high-pass-filter enable flag for the converter datapath downstream. A power-down input stops all generation and measurement. A one-cycle strobe marks every falling edge of the bit clock so that serial data can be shifted out on it.

Top module: `audio_clkgen`

## Requirements
- R1: Mode decode. Codes 3'b000, 3'b001 and 3'b100 select slave (`slave_mode`=1). All other codes select master or reserved (`slave_mode`=0). `hpf_on` is 0 for codes 3'b001 and 3'b111 and 1 for every other code.
- R2: In master mode the bit clock period is ratio/64 master-clock cycles. The ratio is 256 for code 3'b010, 512 for 3'b011, 384 for 3'b101 and 768 for 3'b110.
- R3: In master mode the frame clock period is `ratio` master-clock cycles. The frame clock is high for ratio/2 cycles and low for ratio/2 cycles, which is 32 bit clocks each.
- R4: In master mode the frame clock changes only in a cycle in which `bclk_fall` is 1.
- R5: `bclk_fall` is 1 for exactly those cycles in which `bclk` is 0 and was 1 in the previous cycle, in both master and slave mode.
- R6: While `pwr_dn` is 1, `bclk`, `fsync` and `bclk_fall` are 0 and the divider state is cleared. After release in master mode, both clocks start low and the first rising edge of `fsync` is seen ratio/2 cycles after release.
- R7: Code 3'b111 is reserved. It keeps `bclk`, `fsync` and `bclk_fall` at 0 as power-down does.
- R8: In slave mode `bclk` and `fsync` follow `ext_bclk` and `ext_fsync` with a delay of two master-clock cycles. Every external bit clock falling edge gives one `bclk_fall` pulse.
- R9: In slave mode the block counts `bclk_fall` pulses from one `fsync` rise to the next. A pulse in the same cycle as the closing rise counts toward the frame that is ending. A count of 32 gives `rate_ok`=1 and `rate_48`=0. A count of 48 gives `rate_ok`=1 and `rate_48`=1. Any other count gives `rate_ok`=0 and `rate_48`=0. The first rise after start only arms the count and updates nothing.
- R10: Power-down or leaving slave mode clears `rate_ok` and `rate_48` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_dn | input | 1 | Power-down, active high |
| mode | input | 3 | Mode code |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_fsync | input | 1 | External frame clock (slave mode) |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame clock |
| bclk_fall | output | 1 | Strobe marking a bit clock falling edge |
| slave_mode | output | 1 | 1 when the mode code selects slave |
| hpf_on | output | 1 | High-pass-filter enable |
| rate_ok | output | 1 | Slave frame measured as 32 or 48 bit clocks |
| rate_48 | output | 1 | Slave frame measured as 48 bit clocks |

## Verification
In slave mode, a rise of the frame clock and a falling edge of the bit clock can reach the measurement logic in the same cycle. That cycle must close the frame and also count the coincident edge. The bench drives external clocks whose frame edges coincide exactly with bit clock falling edges, so both synchronised events appear together. It then checks that a 48-bit frame is still reported as 48 rather than 47. A second run moves the frame edges into the high phase of the bit clock so the two events fall in different cycles, and the same count is expected. In master mode the frame toggle and the falling-edge strobe always coincide by design, and the bench checks this on every cycle.

// File: rtl/acg_pkg.sv
package acg_pkg;

  typedef enum logic [1:0] {RAT_256, RAT_384, RAT_512, RAT_768} ratio_e;

  typedef struct packed {
    logic   slave;
    logic   hpf;
    logic   rsvd;
    ratio_e ratio;
  } mode_t;

  // Mode code to operating settings.
  function automatic mode_t decode_mode(input logic [2:0] code);
    mode_t d;
    d = '{slave: 1'b0, hpf: 1'b1, rsvd: 1'b0, ratio: RAT_256};
    case (code)
      3'b000: d.slave = 1'b1;
      3'b001: begin d.slave = 1'b1; d.hpf = 1'b0; end
      3'b010: d.ratio = RAT_256;
      3'b011: d.ratio = RAT_512;
      3'b100: d.slave = 1'b1;
      3'b101: d.ratio = RAT_384;
      3'b110: d.ratio = RAT_768;
      default: begin d.rsvd = 1'b1; d.hpf = 1'b0; end
    endcase
    return d;
  endfunction

  // Master-clock cycles per half bit clock: ratio / 128.
  function automatic logic [2:0] half_period(input ratio_e r);
    case (r)
      RAT_256: return 3'd2;
      RAT_384: return 3'd3;
      RAT_512: return 3'd4;
      default: return 3'd6;
    endcase
  endfunction

endpackage

// File: rtl/acg_mst_div.sv
module acg_mst_div #(
  parameter int HCNT_W    = 3,
  parameter int BITS_HALF = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HCNT_W-1:0] half,
  output logic              bclk,
  output logic              fsync,
  output logic              fall
);
  localparam int BCNT_W = $clog2(BITS_HALF);

  logic [HCNT_W-1:0] hcnt;
  logic [BCNT_W-1:0] bcnt;
  logic              bclk_q, fs_q, fall_q;

  wire half_done = (hcnt >= half - 1'b1);
  wire fall_now  = half_done & bclk_q;
  wire word_done = fall_now & (bcnt == BCNT_W'(BITS_HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0; bcnt <= '0; bclk_q <= 1'b0; fs_q <= 1'b0; fall_q <= 1'b0;
    end else if (!run) begin
      hcnt <= '0; bcnt <= '0; bclk_q <= 1'b0; fs_q <= 1'b0; fall_q <= 1'b0;
    end else begin
      fall_q <= fall_now;
      if (half_done) begin
        hcnt   <= '0;
        bclk_q <= ~bclk_q;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
      if (word_done)     bcnt <= '0;
      else if (fall_now) bcnt <= bcnt + 1'b1;
      if (word_done) fs_q <= ~fs_q;
    end
  end

  assign bclk  = bclk_q;
  assign fsync = fs_q;
  assign fall  = fall_q;

  // R5: strobe marks the cycle right after the bit clock fell
  p_strobe_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> $fell(bclk_q));

  // R4: frame clock toggles only together with a falling-edge strobe
  p_fs_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (fs_q != $past(fs_q))) |-> fall_q);

  // R2: half-period counter stays in range while the ratio is steady
  p_hcnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $stable(half)) |-> (hcnt < half));

endmodule

// File: rtl/acg_slv_mon.sv
module acg_slv_mon #(
  parameter int CNT_W   = 7,
  parameter int LO_BITS = 32,
  parameter int HI_BITS = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ext_bclk,
  input  logic ext_fsync,
  output logic bclk,
  output logic fsync,
  output logic fall,
  output logic rate_ok,
  output logic rate_48
);
  logic             b1, b2, b3, f1, f2, f3, armed, ok_q, r48_q;
  logic [CNT_W-1:0] cnt;

  wire              fall_w  = b3 & ~b2;
  wire              fs_rise = f2 & ~f3;
  wire [CNT_W-1:0]  total   = cnt + CNT_W'(fall_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {b1, b2, b3, f1, f2, f3} <= '0;
      cnt <= '0; armed <= 1'b0; ok_q <= 1'b0; r48_q <= 1'b0;
    end else if (!run) begin
      {b1, b2, b3, f1, f2, f3} <= '0;
      cnt <= '0; armed <= 1'b0; ok_q <= 1'b0; r48_q <= 1'b0;
    end else begin
      b1 <= ext_bclk;  b2 <= b1; b3 <= b2;
      f1 <= ext_fsync; f2 <= f1; f3 <= f2;
      if (fs_rise) begin
        cnt   <= '0;
        armed <= 1'b1;
        if (armed) begin
          ok_q  <= (total == CNT_W'(LO_BITS)) || (total == CNT_W'(HI_BITS));
          r48_q <= (total == CNT_W'(HI_BITS));
        end
      end else if (fall_w && (cnt != '1)) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign bclk    = b2;
  assign fsync   = f2;
  assign fall    = fall_w;
  assign rate_ok = ok_q;
  assign rate_48 = r48_q;

  // R9: a 48 report is always a valid report
  p_r48_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    r48_q |-> ok_q);

  // R9: flags move only after a frame rise while running
  p_flag_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$stable(ok_q)) |-> $past(fs_rise));

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_dn,
  input  logic [2:0] mode,
  input  logic       ext_bclk,
  input  logic       ext_fsync,
  output logic       bclk,
  output logic       fsync,
  output logic       bclk_fall,
  output logic       slave_mode,
  output logic       hpf_on,
  output logic       rate_ok,
  output logic       rate_48
);
  import acg_pkg::*;

  localparam int HCNT_W    = 3;
  localparam int BITS_HALF = 32;

  mode_t dec;
  assign dec = decode_mode(mode);

  wire m_run = ~pwr_dn & ~dec.rsvd & ~dec.slave;
  wire s_run = ~pwr_dn & dec.slave;

  logic m_bclk, m_fs, m_fall, s_bclk, s_fs, s_fall;

  acg_mst_div #(.HCNT_W(HCNT_W), .BITS_HALF(BITS_HALF)) u_mst (
    .clk(clk), .rst_n(rst_n), .run(m_run),
    .half(HCNT_W'(half_period(dec.ratio))),
    .bclk(m_bclk), .fsync(m_fs), .fall(m_fall)
  );

  acg_slv_mon #(.CNT_W(7), .LO_BITS(BITS_HALF), .HI_BITS(48)) u_slv (
    .clk(clk), .rst_n(rst_n), .run(s_run),
    .ext_bclk(ext_bclk), .ext_fsync(ext_fsync),
    .bclk(s_bclk), .fsync(s_fs), .fall(s_fall),
    .rate_ok(rate_ok), .rate_48(rate_48)
  );

  assign bclk       = (s_run & s_bclk) | (m_run & m_bclk);
  assign fsync      = (s_run & s_fs)   | (m_run & m_fs);
  assign bclk_fall  = (s_run & s_fall) | (m_run & m_fall);
  assign slave_mode = dec.slave;
  assign hpf_on     = dec.hpf;

  // R6: after power-down release both clocks begin low
  p_release_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pwr_dn) && !dec.slave) |-> (!m_bclk && !m_fs));

endmodule

// File: tb/test_audio_clkgen.sv
module test_audio_clkgen;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, pwr_dn = 1'b1;
  logic [2:0] mode = 3'b010;
  logic ext_bclk = 1'b0, ext_fsync = 1'b0;
  logic bclk, fsync, bclk_fall, slave_mode, hpf_on, rate_ok, rate_48;

  int n_chk = 0, n_bad = 0;
  bit mon_on = 1'b0;
  int fall_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_clkgen i_audio_clkgen (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .mode(mode),
    .ext_bclk(ext_bclk), .ext_fsync(ext_fsync),
    .bclk(bclk), .fsync(fsync), .bclk_fall(bclk_fall),
    .slave_mode(slave_mode), .hpf_on(hpf_on),
    .rate_ok(rate_ok), .rate_48(rate_48)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Per-cycle monitor for R4 and R5.
  logic prev_bclk = 1'b0, prev_fs = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (bclk_fall) chk(prev_bclk && !bclk, "R5 strobe without fall", {prev_bclk, bclk}, 2);
      if (fsync != prev_fs) chk(bclk_fall, "R4 fsync toggled off strobe", bclk_fall, 1);
    end
    if (bclk_fall) fall_seen++;
    prev_bclk = bclk;
    prev_fs   = fsync;
  end

  task automatic t_reset;
    @(negedge clk);
    chk(!bclk && !fsync && !bclk_fall, "R6 reset outputs", {bclk, fsync, bclk_fall}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_decode;
    for (int c = 0; c < 8; c++) begin
      bit exp_s, exp_h;
      mode = 3'(c);
      exp_s = (c == 0) || (c == 1) || (c == 4);
      exp_h = !((c == 1) || (c == 7));
      #1;
      chk(slave_mode == exp_s, $sformatf("R1 slave flag code %0d", c), slave_mode, exp_s);
      chk(hpf_on == exp_h, $sformatf("R1 hpf flag code %0d", c), hpf_on, exp_h);
    end
  endtask

  task automatic t_master(input logic [2:0] code, input int ratio);
    int n;
    pwr_dn = 1'b1; mode = code;
    repeat (3) @(negedge clk);
    chk(!bclk && !fsync, "R6 held low in power-down", {bclk, fsync}, 0);
    pwr_dn = 1'b0;
    mon_on = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!fsync && n < 5000);
    chk(n == ratio/2, $sformatf("R6 first fsync rise ratio %0d", ratio), n, ratio/2);
    while (!bclk_fall) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (!bclk_fall && n < 100);
    chk(n == ratio/64, $sformatf("R2 bclk period ratio %0d", ratio), n, ratio/64);
    while (fsync) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (!fsync && n < 5000);
    chk(n == ratio/2, $sformatf("R3 fsync low time ratio %0d", ratio), n, ratio/2);
    n = 0;
    do begin @(negedge clk); n++; end while (fsync && n < 5000);
    chk(n == ratio/2, $sformatf("R3 fsync high time ratio %0d", ratio), n, ratio/2);
    mon_on = 1'b0;
  endtask

  task automatic t_pdn_mid;
    bit seen = 1'b0;
    pwr_dn = 1'b0; mode = 3'b010;
    repeat (300) @(negedge clk);
    pwr_dn = 1'b1;
    #1;
    chk(!bclk && !fsync && !bclk_fall, "R6 outputs drop on power-down", {bclk, fsync, bclk_fall}, 0);
    repeat (100) begin @(negedge clk); if (bclk || fsync || bclk_fall) seen = 1'b1; end
    chk(!seen, "R6 quiet during power-down", seen, 0);
  endtask

  task automatic t_reserved;
    bit seen = 1'b0;
    mode = 3'b111; pwr_dn = 1'b0;
    repeat (400) begin @(negedge clk); if (bclk || fsync || bclk_fall) seen = 1'b1; end
    chk(!seen, "R7 reserved code keeps clocks low", seen, 0);
  endtask

  task automatic t_slave_latency;
    pwr_dn = 1'b0; mode = 3'b000; ext_bclk = 1'b0; ext_fsync = 1'b0;
    repeat (4) @(negedge clk);
    ext_bclk = 1'b1; ext_fsync = 1'b1;
    @(negedge clk);
    chk(!bclk && !fsync, "R8 not yet through after one cycle", {bclk, fsync}, 0);
    @(negedge clk);
    chk(bclk && fsync, "R8 through after two cycles", {bclk, fsync}, 3);
    ext_bclk = 1'b0; ext_fsync = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // Drive frames of `bits` bit clocks; fsync edges aligned to bclk fall or shifted into high phase.
  task automatic drive_frames(input int bits, input int nf, input int hp, input bit shifted);
    for (int f = 0; f < nf; f++) begin
      for (int b = 0; b < bits; b++) begin
        ext_bclk = 1'b0;
        if (!shifted && b == 0)      ext_fsync = 1'b0;
        if (!shifted && b == bits/2) ext_fsync = 1'b1;
        repeat (hp) @(negedge clk);
        ext_bclk = 1'b1;
        repeat (hp/2) @(negedge clk);
        if (shifted && b == 0)      ext_fsync = 1'b0;
        if (shifted && b == bits/2) ext_fsync = 1'b1;
        repeat (hp - hp/2) @(negedge clk);
      end
    end
  endtask

  task automatic t_slave(input int bits, input bit shifted, input bit exp_ok, input bit exp_48);
    int start;
    pwr_dn = 1'b1; mode = 3'b000; ext_bclk = 1'b1; ext_fsync = 1'b0;
    repeat (3) @(negedge clk);
    pwr_dn = 1'b0;
    repeat (4) @(negedge clk);
    start = fall_seen;
    drive_frames(bits, 1, 4, shifted);
    chk(!rate_ok, $sformatf("R9 first rise only arms (%0d bits)", bits), rate_ok, 0);
    drive_frames(bits, 3, 4, shifted);
    repeat (4) @(negedge clk);
    chk(fall_seen - start == 4*bits, $sformatf("R8 one strobe per ext fall (%0d bits)", bits),
        fall_seen - start, 4*bits);
    chk(rate_ok == exp_ok, $sformatf("R9 rate_ok for %0d bits shifted=%0d", bits, shifted), rate_ok, exp_ok);
    chk(rate_48 == exp_48, $sformatf("R9 rate_48 for %0d bits shifted=%0d", bits, shifted), rate_48, exp_48);
    pwr_dn = 1'b1;
    @(negedge clk);
    chk(!rate_ok && !rate_48, "R10 flags cleared by power-down", {rate_ok, rate_48}, 0);
  endtask

  task automatic t_leave_slave;
    pwr_dn = 1'b0; mode = 3'b000; ext_bclk = 1'b1; ext_fsync = 1'b0;
    repeat (4) @(negedge clk);
    drive_frames(48, 3, 4, 1'b0);
    repeat (4) @(negedge clk);
    chk(rate_ok && rate_48, "R9 48-bit frames before mode change", {rate_ok, rate_48}, 3);
    mode = 3'b010;
    @(negedge clk);
    chk(!rate_ok && !rate_48, "R10 flags cleared on leaving slave", {rate_ok, rate_48}, 0);
  endtask

  bit done = 1'b0;
  initial begin
    t_reset();
    t_decode();
    t_master(3'b010, 256);
    t_master(3'b101, 384);
    t_master(3'b011, 512);
    t_master(3'b110, 768);
    t_pdn_mid();
    t_reserved();
    t_slave_latency();
    t_slave(48, 1'b0, 1'b1, 1'b1);
    t_slave(48, 1'b1, 1'b1, 1'b1);
    t_slave(32, 1'b0, 1'b1, 1'b0);
    t_slave(32, 1'b1, 1'b1, 1'b0);
    t_slave(40, 1'b0, 1'b0, 1'b0);
    t_leave_slave();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule